// File: doc/BRIEF.md
# Protection Region Configuration Register File

This block stores the programming of a parameterized set of physical-memory-protection regions. The default is eight. Each region has an 8-bit configuration byte and an address register. The configuration byte holds read, write and execute permissions, an address-match mode and a lock flag. Configuration bytes are packed into wider configuration words, one byte lane per region. The address register holds physical address bits [33:2], so a 34-bit physical address fits in a 32-bit register.

A single write port carries:
- a select between a configuration word and an address register,
- an index,
- a data word,
- a strobe.

Before a written value is stored, the block legalizes it. Writes that a lock forbids are dropped without any response. A locked region ignores writes to its own configuration byte and to its own address register. A locked region in top-of-range mode also freezes the address register of the region below it, because that register is its lower bound.

A combinational read port returns either a packed configuration word or one address register. Flat copies of every stored byte and address go out to a separate access checker.

Top module: `prot_region_cfg`

## Requirements
- R1: After reset, every configuration byte and every address register reads as zero.
- R2: Bits 6:5 of every configuration byte always read as zero, whatever value was written to them.
- R3: While a region's lock flag (bit 7) is 1, writes to that region's configuration byte and to its address register leave both unchanged.
- R4: A lock flag that has been set stays set through any later write and is cleared only by reset.
- R5: When region i is locked and its mode field (bits 4:3) equals 1 (top-of-range), writes to the address register of region i-1 are dropped, even if region i-1 is unlocked. A locked region in any other mode does not affect region i-1.
- R6: When a written configuration byte has read permission (bit 0) equal to 0 and write permission (bit 1) equal to 1, it is stored with bit 1 cleared.
- R7: When GRAIN_LOG2 > 2, a write whose mode field is 2 (four-byte region) keeps the region's previous mode field; the other fields are still written. When GRAIN_LOG2 = 2, mode 2 is stored as written.
- R8: A configuration-word write updates, byte lane by byte lane, only the regions whose own lock flags are clear. Locked and unlocked regions can therefore share one write.
- R9: A write takes effect at the next rising clock edge. Reading configuration word k returns region k*B+j in bits 8j+7:8j, where B = XLEN/8. Reading address register i returns the stored value.
- R10: Region 0 has no region below it. Locking region 0 in top-of-range mode freezes only region 0's own registers and does not block writes to any other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_is_cfg | input | 1 | 1: write a configuration word, 0: write an address register |
| wr_idx | input | IDX_W | Configuration word index or region index |
| wr_data | input | XLEN | Write data |
| rd_is_cfg | input | 1 | 1: read a configuration word, 0: read an address register |
| rd_idx | input | IDX_W | Read index; out-of-range indices return zero |
| rd_data | output | XLEN | Combinational read data |
| cfg_flat | output | NUM_ENTRIES*8 | All configuration bytes, region i at bits 8i+7:8i |
| addr_flat | output | NUM_ENTRIES*XLEN | All address registers, region i at lane i |

## Verification
Assertions check on every cycle that reserved bits are zero and that the pattern with write permission but no read permission is never stored. They also check that lock flags never fall outside reset and that a locked region's registers stay stable. Further assertions check that an address register stays stable whenever the region above it holds a top-of-range lock, that the four-byte mode never appears when the grain forbids it, and that an unlocked write lands in the following cycle.

Only the bench scenarios can show the absolute stored values: the packing order inside a configuration word, and the mixed write in which locked and unlocked lanes meet. The same holds for the contrast between the two grain settings and for lock release by a second reset. The bench compares both instances against a behavioural model after every clock.

// File: rtl/prc_pkg.sv
`timescale 1ns/1ps
package prc_pkg;

   localparam int CFG_BITS = 8;

   typedef enum logic [1:0] {
      AM_OFF   = 2'd0,
      AM_TOR   = 2'd1,
      AM_NA4   = 2'd2,
      AM_NAPOT = 2'd3
   } amode_e;

   // bit order is behaviour: the access checker decodes these positions
   typedef struct packed {
      logic       lock;   // 7
      logic [1:0] rsvd;   // 6:5
      amode_e     amode;  // 4:3
      logic       x;      // 2
      logic       w;      // 1
      logic       r;      // 0
   } cfg_t;

endpackage

// File: rtl/prc_cfg_legalize.sv
`timescale 1ns/1ps
module prc_cfg_legalize
   import prc_pkg::*;
#(
   parameter int GRAIN_LOG2 = 2
) (
   input  cfg_t wr_val,
   output cfg_t legal_val,
   output logic keep_amode
);

   localparam bit NA4_OK = (GRAIN_LOG2 == 2);

   always_comb begin
      legal_val      = wr_val;
      legal_val.rsvd = '0;
      if (!wr_val.r) begin
         legal_val.w = 1'b0;
      end
   end

   generate
      if (NA4_OK) begin : g_na4_allowed
         assign keep_amode = 1'b0;
      end else begin : g_na4_blocked
         assign keep_amode = (wr_val.amode == AM_NA4);
      end
   endgenerate

   always_comb begin
      assert (legal_val.rsvd == 2'b00) else $error("AST_LEGAL_RSVD");           // R2
      assert (!(legal_val.w && !legal_val.r)) else $error("AST_LEGAL_WNR");      // R6
   end

endmodule

// File: rtl/prc_entry.sv
`timescale 1ns/1ps
module prc_entry
   import prc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int GRAIN_LOG2 = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  cfg_t            cfg_wdata,
   input  logic            addr_we,
   input  logic [XLEN-1:0] addr_wdata,
   input  logic            next_tor_lock,
   output cfg_t            cfg_q,
   output logic [XLEN-1:0] addr_q,
   output logic            tor_lock
);

   cfg_t legal;
   cfg_t cfg_d;
   logic keep_amode;
   logic cfg_upd;
   logic addr_upd;

   prc_cfg_legalize #(
      .GRAIN_LOG2 (GRAIN_LOG2)
   ) u_legal (
      .wr_val     (cfg_wdata),
      .legal_val  (legal),
      .keep_amode (keep_amode)
   );

   always_comb begin
      cfg_d = legal;
      if (keep_amode) begin
         cfg_d.amode = cfg_q.amode;
      end
   end

   assign cfg_upd  = cfg_we  & ~cfg_q.lock;
   assign addr_upd = addr_we & ~cfg_q.lock & ~next_tor_lock;
   assign tor_lock = cfg_q.lock & (cfg_q.amode == AM_TOR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_upd) begin
         cfg_q <= cfg_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_upd) begin
         addr_q <= addr_wdata;
      end
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.rsvd == 2'b00);                                                   // R2
   AST_NO_W_WITHOUT_R: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_q.w && !cfg_q.r));                                                // R6
   AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock |=> $stable(cfg_q) && $stable(addr_q));                      // R3
   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock |=> cfg_q.lock);                                             // R4
   AST_TOR_PREV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      next_tor_lock |=> $stable(addr_q));                                     // R5
   AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_q.lock |=> cfg_q.r == $past(cfg_wdata.r)
                              && cfg_q.x == $past(cfg_wdata.x)
                              && cfg_q.lock == $past(cfg_wdata.lock));        // R8
   AST_ADDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      addr_we && !cfg_q.lock && !next_tor_lock |=> addr_q == $past(addr_wdata)); // R9

   generate
      if (GRAIN_LOG2 > 2) begin : g_chk_na4
         AST_NO_NA4: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q.amode != AM_NA4);                                           // R7
      end
   endgenerate

endmodule

// File: rtl/prot_region_cfg.sv
`timescale 1ns/1ps
module prot_region_cfg
   import prc_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int XLEN        = 32,
   parameter int GRAIN_LOG2  = 2,
   localparam int EPW        = XLEN / CFG_BITS,
   localparam int NUM_WORDS  = (NUM_ENTRIES + EPW - 1) / EPW,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          wr_is_cfg,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [XLEN-1:0]               wr_data,
   input  logic                          rd_is_cfg,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [XLEN-1:0]               rd_data,
   output logic [NUM_ENTRIES*CFG_BITS-1:0] cfg_flat,
   output logic [NUM_ENTRIES*XLEN-1:0]   addr_flat
);

   generate
      if (NUM_ENTRIES < 1) begin : g_bad_count
         $error("NUM_ENTRIES must be at least 1");
      end
      if ((XLEN % CFG_BITS) != 0 || XLEN < CFG_BITS) begin : g_bad_xlen
         $error("XLEN must be a positive multiple of 8");
      end
      if (GRAIN_LOG2 < 2) begin : g_bad_grain
         $error("GRAIN_LOG2 must be at least 2");
      end
   endgenerate

   cfg_t            cfg_q    [NUM_ENTRIES];
   logic [XLEN-1:0] addr_q   [NUM_ENTRIES];
   logic [NUM_ENTRIES-1:0] tor_lock;
   logic [NUM_ENTRIES-1:0] nxt_lock;
   logic [NUM_ENTRIES-1:0] addr_we;
   logic [XLEN-1:0] cfg_words [NUM_WORDS];

   genvar gi, gw, gl;
   generate
      for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
         logic cfg_we;
         assign cfg_we      = wr_en & wr_is_cfg  & (wr_idx == IDX_W'(gi / EPW));
         assign addr_we[gi] = wr_en & ~wr_is_cfg & (wr_idx == IDX_W'(gi));

         if (gi == NUM_ENTRIES - 1) begin : g_top
            assign nxt_lock[gi] = 1'b0;
         end else begin : g_mid
            assign nxt_lock[gi] = tor_lock[gi+1];
         end

         prc_entry #(
            .XLEN       (XLEN),
            .GRAIN_LOG2 (GRAIN_LOG2)
         ) u_entry (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_we        (cfg_we),
            .cfg_wdata     (cfg_t'(wr_data[(gi % EPW)*CFG_BITS +: CFG_BITS])),
            .addr_we       (addr_we[gi]),
            .addr_wdata    (wr_data),
            .next_tor_lock (nxt_lock[gi]),
            .cfg_q         (cfg_q[gi]),
            .addr_q        (addr_q[gi]),
            .tor_lock      (tor_lock[gi])
         );

         assign cfg_flat[gi*CFG_BITS +: CFG_BITS] = cfg_q[gi];
         assign addr_flat[gi*XLEN +: XLEN]        = addr_q[gi];
      end

      for (gw = 0; gw < NUM_WORDS; gw++) begin : g_word
         for (gl = 0; gl < EPW; gl++) begin : g_lane
            if (gw * EPW + gl < NUM_ENTRIES) begin : g_used
               assign cfg_words[gw][gl*CFG_BITS +: CFG_BITS] = cfg_q[gw*EPW + gl];
            end else begin : g_pad
               assign cfg_words[gw][gl*CFG_BITS +: CFG_BITS] = '0;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_is_cfg) begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_idx == IDX_W'(w)) begin
               rd_data = cfg_words[w];
            end
         end
      end else begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (rd_idx == IDX_W'(e)) begin
               rd_data = addr_q[e];
            end
         end
      end
   end

   generate
      if (NUM_ENTRIES > 2) begin : g_chk_e0
         // region 0 locked in top-of-range mode must not shield region 1
         AST_E0_LOCKS_NOTHING_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
            tor_lock[0] && addr_we[1] && !cfg_q[1].lock && !tor_lock[2]
            |=> addr_q[1] == $past(wr_data));                                 // R10
      end
   endgenerate

endmodule

// File: tb/test_prot_region_cfg.sv
`timescale 1ns/1ps
module test_prot_region_cfg;

   localparam int N = 8;
   localparam int XL = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_is_cfg = 1'b0;
   logic [2:0] wr_idx = '0;
   logic [XL-1:0] wr_data = '0;
   logic rd_is_cfg = 1'b0;
   logic [2:0] rd_idx = '0;
   logic [XL-1:0] rd_a, rd_b;
   logic [N*8-1:0] cf_a, cf_b;
   logic [N*XL-1:0] af_a, af_b;

   int checks = 0;
   int fails = 0;
   string cur_req = "R1";

   logic [7:0]    m_cfg  [2][N];
   logic [XL-1:0] m_addr [2][N];

   always #2.5 clk = ~clk;

   prot_region_cfg #(.NUM_ENTRIES(N), .XLEN(XL), .GRAIN_LOG2(2)) i_prot_region_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_cfg(wr_is_cfg), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_is_cfg(rd_is_cfg), .rd_idx(rd_idx), .rd_data(rd_a),
      .cfg_flat(cf_a), .addr_flat(af_a));

   prot_region_cfg #(.NUM_ENTRIES(N), .XLEN(XL), .GRAIN_LOG2(3)) i_prot_region_cfg_g8 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_cfg(wr_is_cfg), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_is_cfg(rd_is_cfg), .rd_idx(rd_idx), .rd_data(rd_b),
      .cfg_flat(cf_b), .addr_flat(af_b));

   // behavioural reference model, one copy per grain setting
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++)
            for (int e = 0; e < N; e++) begin
               m_cfg[k][e] = 8'h00;
               m_addr[k][e] = '0;
            end
      end else if (wr_en) begin
         for (int k = 0; k < 2; k++) begin
            if (wr_is_cfg) begin
               for (int j = 0; j < 4; j++) begin
                  int e;
                  logic [7:0] nb;
                  e = int'(wr_idx) * 4 + j;
                  if (e < N && !m_cfg[k][e][7]) begin
                     nb = wr_data[j*8 +: 8];
                     nb[6:5] = 2'b00;
                     if (!nb[0]) nb[1] = 1'b0;
                     if (k == 1 && nb[4:3] == 2'd2) nb[4:3] = m_cfg[k][e][4:3];
                     m_cfg[k][e] = nb;
                  end
               end
            end else begin
               int e;
               bit blocked;
               e = int'(wr_idx);
               blocked = m_cfg[k][e][7];
               if (e + 1 < N && m_cfg[k][e+1][7] && m_cfg[k][e+1][4:3] == 2'd1) blocked = 1'b1;
               if (!blocked) m_addr[k][e] = wr_data;
            end
         end
      end
   end

   function automatic logic [XL-1:0] model_read(int k);
      logic [XL-1:0] v;
      v = '0;
      if (rd_is_cfg) begin
         for (int j = 0; j < 4; j++)
            if (int'(rd_idx) * 4 + j < N) v[j*8 +: 8] = m_cfg[k][int'(rd_idx)*4 + j];
      end else begin
         v = m_addr[k][int'(rd_idx)];
      end
      return v;
   endfunction

   task automatic chk(string req, string what, logic [N*XL-1:0] act, logic [N*XL-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // every clock: compare both instances with the model, one step after the edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            logic [N*8-1:0]  ecf;
            logic [N*XL-1:0] eaf;
            for (int e = 0; e < N; e++) begin
               ecf[e*8 +: 8] = m_cfg[k][e];
               eaf[e*XL +: XL] = m_addr[k][e];
            end
            chk(cur_req, k == 0 ? "cfg_flat g4" : "cfg_flat g8",
                (N*XL)'(k == 0 ? cf_a : cf_b), (N*XL)'(ecf));
            chk(cur_req, k == 0 ? "addr_flat g4" : "addr_flat g8", k == 0 ? af_a : af_b, eaf);
            chk(cur_req, k == 0 ? "rd_data g4" : "rd_data g8",
                (N*XL)'(k == 0 ? rd_a : rd_b), (N*XL)'(model_read(k)));
         end
      end
   end

   task automatic wr(bit is_cfg, int idx, logic [XL-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_is_cfg = is_cfg; wr_idx = 3'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(string req, bit is_cfg, int idx, logic [XL-1:0] exp_a, logic [XL-1:0] exp_b);
      @(negedge clk);
      rd_is_cfg = is_cfg; rd_idx = 3'(idx);
      #0.5;
      chk(req, "read g4", (N*XL)'(rd_a), (N*XL)'(exp_a));
      chk(req, "read g8", (N*XL)'(rd_b), (N*XL)'(exp_b));
   endtask

   initial begin
      #1000000;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      rd("R1", 1, 0, 32'h0, 32'h0);
      rd("R1", 0, 3, 32'h0, 32'h0);
      // R9 address write and read back
      cur_req = "R9";
      wr(0, 2, 32'h1234_5678);
      rd("R9", 0, 2, 32'h1234_5678, 32'h1234_5678);
      // R2/R6/R9 legalization and lane packing; lane3 becomes locked
      cur_req = "R6";
      wr(1, 0, 32'hE37A_021F);
      rd("R2 R6 R9", 1, 0, 32'h8318_001F, 32'h8318_001F);
      // R8 mixed word write: unlocked lanes clear, locked lane kept
      cur_req = "R8";
      wr(1, 0, 32'h0000_0000);
      rd("R8", 1, 0, 32'h8300_0000, 32'h8300_0000);
      // R3 locked region address frozen
      cur_req = "R3";
      wr(0, 3, 32'hDEAD_BEEF);
      rd("R3", 0, 3, 32'h0, 32'h0);
      // R5 non-TOR lock leaves region below writable
      cur_req = "R5";
      wr(0, 2, 32'h0000_0055);
      rd("R5", 0, 2, 32'h55, 32'h55);
      // R5 region 6 locked TOR freezes region 5 address
      wr(1, 1, 32'h0089_0000);
      rd("R9", 1, 1, 32'h0089_0000, 32'h0089_0000);
      wr(0, 5, 32'h0000_AAAA);
      rd("R5", 0, 5, 32'h0, 32'h0);
      wr(0, 6, 32'h0000_BBBB);
      rd("R3", 0, 6, 32'h0, 32'h0);
      wr(0, 4, 32'h0000_0077);
      rd("R5", 0, 4, 32'h77, 32'h77);
      // R10 region 0 locked TOR shields nobody else
      cur_req = "R10";
      wr(1, 0, 32'h0000_0089);
      rd("R10", 1, 0, 32'h8300_0089, 32'h8300_0089);
      wr(0, 0, 32'h0000_FFFF);
      rd("R10", 0, 0, 32'h0, 32'h0);
      wr(0, 1, 32'h0000_0011);
      rd("R10", 0, 1, 32'h11, 32'h11);
      wr(0, 7, 32'h0000_0707);
      rd("R10", 0, 7, 32'h707, 32'h707);
      // R4 locks survive writes, clear only on reset
      cur_req = "R4";
      wr(1, 0, 32'h0000_0000);
      rd("R4", 1, 0, 32'h8300_0089, 32'h8300_0089);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      rd("R4", 1, 0, 32'h0, 32'h0);
      rd("R1", 0, 2, 32'h0, 32'h0);
      wr(1, 0, 32'h0000_0003);
      rd("R4", 1, 0, 32'h3, 32'h3);
      // R7 four-byte mode depends on grain
      cur_req = "R7";
      wr(1, 0, 32'h0000_0013);
      rd("R7", 1, 0, 32'h13, 32'h03);
      wr(1, 0, 32'h0000_0018);
      rd("R7", 1, 0, 32'h18, 32'h18);
      wr(1, 0, 32'h0000_0010);
      rd("R7", 1, 0, 32'h10, 32'h18);
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule